// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Timer

This block is the digital core of a processor supervisor. It drives a processor reset in both polarities and a separate active-low watchdog flag. Its time base is a slow oscillator tick enable. Reset stays active for as long as a synchronized low-supply flag is raised. After the flag clears, reset stays active for a fixed number of further ticks. The same stretch sequence runs again whenever the watchdog expires.

Software services the watchdog by toggling a pin. Either a rising or a falling edge counts as a service. When reset ends, a long grace timeout applies, so that software has time to start. The first service after reset switches to a short normal timeout, which stays in force until the next reset. A select input chooses the tick source: the internal oscillator tick or an external clock tick. Both sources pass through the same one-flop tick stage before they reach the counter.

Top module: `supervisor_wdt`

## Requirements
- R1: After the synchronous power-on clear, `rst_o` is 1, `rst_n_o` is 0 and `wdo_n` is 1. The block then runs the reset stretch with the long timeout armed.
- R2: When `low_supply` is 1, `rst_o` is 1 from the next clock edge on. It stays 1 while `low_supply` stays 1, no matter how many ticks arrive.
- R3: Once `low_supply` is 0, reset is released on exactly the `STRETCH_TICKS`-th selected tick. A new low-supply dip during the stretch restarts the count from zero.
- R4: `rst_n_o` is always the bitwise inverse of `rst_o`.
- R5: After every reset, the watchdog expires on the `LONG_TICKS`-th tick if no service arrives. In particular, no expiry occurs after `SHORT_TICKS` ticks.
- R6: Once a service has arrived after reset, the watchdog expires on the `SHORT_TICKS`-th tick after the most recent service.
- R7: `wd_in` passes through a two-flop synchronizer. A rising or a falling edge each counts as a service and restarts the watchdog count.
- R8: On expiry, `wdo_n` goes to 0 and `rst_o` goes to 1. A full `STRETCH_TICKS` stretch follows, with the long timeout re-armed.
- R9: After an expiry, `wdo_n` stays 0 until the next edge on `wd_in`, which sets it to 1. `low_supply` = 1 also forces it to 1.
- R10: When `osc_sel` is 0, only `int_tick` advances the counters. When `osc_sel` is 1, only `ext_tick` advances them. The tick that is not selected has no effect.
- R11: While reset is active, the watchdog cannot expire, and `wdo_n` never falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on clear |
| int_tick | input | 1 | Internal oscillator tick enable, one cycle wide |
| ext_tick | input | 1 | External clock tick enable, one cycle wide |
| osc_sel | input | 1 | Tick source select: 0 selects internal, 1 selects external |
| low_supply | input | 1 | Synchronized flag that the supply is below threshold |
| wd_in | input | 1 | Asynchronous watchdog service pin |
| rst_n_o | output | 1 | Reset, active low |
| rst_o | output | 1 | Reset, active high |
| wdo_n | output | 1 | Watchdog expiry flag, active low |

## Verification
The assertions take three things for granted about the inputs. `low_supply` is already synchronous to `clk`. Tick enables last a single cycle. `wd_in` is low when the power-on clear is released, so that the synchronizer flops, which clear to zero, do not see a false service edge. The stimulus drives each tick for one cycle, followed by three idle cycles, so every tick is consumed before outputs are sampled. The stimulus toggles `wd_in` only between ticks and holds it low through the clear. The sweep runs over small tick limits, so that every stretch, grace and normal window is counted tick by tick up to its boundary.

// File: rtl/svr_pkg.sv
package svr_pkg;

    typedef enum logic [1:0] {
        SV_HOLD    = 2'd0,
        SV_STRETCH = 2'd1,
        SV_RUN     = 2'd2
    } sv_state_e;

    typedef struct packed {
        sv_state_e st;
        logic      long_arm;
        logic      wdo_n;
    } sv_ctl_t;

    localparam sv_ctl_t CTL_CLEAR = '{st: SV_STRETCH, long_arm: 1'b1, wdo_n: 1'b1};

    function automatic int unsigned cnt_width(input int unsigned a,
                                              input int unsigned b,
                                              input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        m = (m > c) ? m : c;
        return (m < 2) ? 1 : $clog2(m + 1);
    endfunction

endpackage

// File: rtl/svr_tick_sel.sv
module svr_tick_sel (
    input  logic clk,
    input  logic rst,
    input  logic int_tick,
    input  logic ext_tick,
    input  logic osc_sel,
    output logic tick_q
);
    always_ff @(posedge clk) begin
        if (rst) tick_q <= 1'b0;
        else     tick_q <= osc_sel ? ext_tick : int_tick;
    end
endmodule

// File: rtl/svr_wd_edge.sv
module svr_wd_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic wd_in,
    output logic svc
);
    logic [SYNC_STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[SYNC_STAGES-1:0], wd_in};
    end

    // Either polarity of transition on the synchronized pin is a service
    assign svc = sh[SYNC_STAGES] ^ sh[SYNC_STAGES-1];
endmodule

// File: rtl/svr_tmr.sv
module svr_tmr #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    input  logic [CW-1:0] last,
    output logic          hit,
    output logic [CW-1:0] cnt
);
    assign hit = inc && !clr && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || clr || hit) cnt <= '0;
        else if (inc)          cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/supervisor_wdt.sv
module supervisor_wdt #(
    parameter int unsigned STRETCH_TICKS = 2048,
    parameter int unsigned LONG_TICKS    = 16384,
    parameter int unsigned SHORT_TICKS   = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic int_tick,
    input  logic ext_tick,
    input  logic osc_sel,
    input  logic low_supply,
    input  logic wd_in,
    output logic rst_n_o,
    output logic rst_o,
    output logic wdo_n
);
    import svr_pkg::*;

    localparam int unsigned CW = cnt_width(STRETCH_TICKS, LONG_TICKS, SHORT_TICKS);
    localparam logic [CW-1:0] S_LAST = CW'(STRETCH_TICKS - 1);
    localparam logic [CW-1:0] L_LAST = CW'(LONG_TICKS - 1);
    localparam logic [CW-1:0] N_LAST = CW'(SHORT_TICKS - 1);

    sv_ctl_t       ctl, ctl_d;
    logic          tick_q, svc, hit, cnt_clr, run;
    logic [CW-1:0] last, cnt;

    svr_tick_sel i_tick (
        .clk(clk), .rst(rst), .int_tick(int_tick), .ext_tick(ext_tick),
        .osc_sel(osc_sel), .tick_q(tick_q)
    );

    svr_wd_edge #(.SYNC_STAGES(2)) i_edge (
        .clk(clk), .rst(rst), .wd_in(wd_in), .svc(svc)
    );

    // One counter serves both the reset stretch and the watchdog window
    svr_tmr #(.CW(CW)) i_tmr (
        .clk(clk), .rst(rst), .clr(cnt_clr), .inc(tick_q),
        .last(last), .hit(hit), .cnt(cnt)
    );

    assign run     = (ctl.st == SV_RUN);
    assign cnt_clr = low_supply || (ctl.st == SV_HOLD) || (run && svc);

    always_comb begin
        case (ctl.st)
            SV_STRETCH: last = S_LAST;
            SV_RUN:     last = ctl.long_arm ? L_LAST : N_LAST;
            default:    last = S_LAST;
        endcase
    end

    always_comb begin
        ctl_d = ctl;
        if (svc) ctl_d.wdo_n = 1'b1;
        if (low_supply) begin
            ctl_d.st       = SV_HOLD;
            ctl_d.long_arm = 1'b1;
            ctl_d.wdo_n    = 1'b1;
        end else begin
            case (ctl.st)
                SV_HOLD:    ctl_d.st = SV_STRETCH;
                SV_STRETCH: if (hit) ctl_d.st = SV_RUN;
                SV_RUN: begin
                    if (svc) begin
                        ctl_d.long_arm = 1'b0;
                    end else if (hit) begin
                        ctl_d.st       = SV_STRETCH;
                        ctl_d.long_arm = 1'b1;
                        ctl_d.wdo_n    = 1'b0;
                    end
                end
                default:    ctl_d.st = SV_STRETCH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctl <= CTL_CLEAR;
        else     ctl <= ctl_d;
    end

    assign rst_o   = !run;
    assign rst_n_o = run;
    assign wdo_n   = ctl.wdo_n;

    // R2: a low supply puts reset active on the following edge
    a_r2_low_supply_resets: assert property (@(posedge clk) disable iff (rst)
        low_supply |=> rst_o);

    // R9: a low supply forces the watchdog flag high
    a_r9_wdo_forced_high: assert property (@(posedge clk) disable iff (rst)
        low_supply |=> wdo_n);

    // R8: an expiry always comes together with reset
    a_r8_expiry_enters_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(wdo_n) |-> rst_o);

    // R11: no expiry can start while reset is active
    a_r11_no_timeout_in_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(wdo_n) |-> $past(run));

    // R3: reset is released only by a consumed tick
    a_r3_release_on_tick: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_o) |-> $past(tick_q));

    // R5: the counter never passes the longest window
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= L_LAST || cnt <= S_LAST);
endmodule

// File: tb/test_supervisor_wdt.sv
module test_supervisor_wdt;
    localparam int S = 8;
    localparam int L = 32;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic int_tick = 1'b0, ext_tick = 1'b0, osc_sel = 1'b0;
    logic low_supply = 1'b0, wd_in = 1'b0;
    logic rst_n_o, rst_o, wdo_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    supervisor_wdt #(.STRETCH_TICKS(S), .LONG_TICKS(L), .SHORT_TICKS(N)) i_supervisor_wdt (
        .clk(clk), .rst(rst), .int_tick(int_tick), .ext_tick(ext_tick),
        .osc_sel(osc_sel), .low_supply(low_supply), .wd_in(wd_in),
        .rst_n_o(rst_n_o), .rst_o(rst_o), .wdo_n(wdo_n)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
        // R4: polarity pair checked at every sample
        checks++;
        if (rst_n_o !== ~rst_o) begin
            fails++;
            $display("FAIL R4: actual rst_n_o %b expected %b", rst_n_o, ~rst_o);
        end
    endtask

    // Each tick: one-cycle pulse, three idle cycles, so it is fully consumed
    task automatic ticks(input int n, input bit use_ext);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (use_ext) ext_tick = 1'b1; else int_tick = 1'b1;
            @(negedge clk);
            ext_tick = 1'b0; int_tick = 1'b0;
            @(negedge clk);
            @(negedge clk);
        end
    endtask

    task automatic toggle();
        @(negedge clk);
        wd_in = ~wd_in;
        repeat (4) @(negedge clk);
    endtask

    task automatic supply(input logic v);
        @(negedge clk);
        low_supply = v;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rst_o", rst_o, 1'b1);
        chk("R1 wdo_n", wdo_n, 1'b1);

        ticks(S - 1, 0); chk("R3 before stretch end", rst_o, 1'b1);
        ticks(1, 0);     chk("R3 stretch end", rst_o, 1'b0);

        ticks(N, 0);         chk("R5 grace exceeds short", rst_o, 1'b0);
        ticks(L - N - 1, 0); chk("R5 one before long", rst_o, 1'b0);
        ticks(1, 0);         chk("R5 long expiry rst", rst_o, 1'b1);
        chk("R8 wdo low on expiry", wdo_n, 1'b0);

        ticks(S - 1, 0); chk("R8 stretch after expiry", rst_o, 1'b1);
        chk("R11 no expiry in reset", wdo_n, 1'b0);
        ticks(1, 0);     chk("R8 stretch end", rst_o, 1'b0);
        chk("R9 wdo held until toggle", wdo_n, 1'b0);
        toggle();        chk("R9 wdo cleared by rising edge", wdo_n, 1'b1);

        ticks(N - 1, 0); chk("R6 short window alive", rst_o, 1'b0);
        toggle();
        ticks(N - 1, 0); chk("R7 falling edge serviced", rst_o, 1'b0);
        toggle();
        ticks(N - 1, 0); chk("R7 rising edge serviced", rst_o, 1'b0);
        ticks(1, 0);     chk("R6 short expiry", rst_o, 1'b1);
        chk("R6 wdo low", wdo_n, 1'b0);

        supply(1'b1);
        chk("R2 reset on low supply", rst_o, 1'b1);
        chk("R9 wdo forced high", wdo_n, 1'b1);
        ticks(2 * L, 0);
        chk("R2 held while low", rst_o, 1'b1);
        chk("R11 wdo stays high in hold", wdo_n, 1'b1);

        supply(1'b0);
        ticks(S - 2, 0);
        supply(1'b1);
        supply(1'b0);
        ticks(S - 1, 0); chk("R3 dip restarts stretch", rst_o, 1'b1);
        ticks(1, 0);     chk("R3 restarted stretch end", rst_o, 1'b0);
        ticks(N + 1, 0); chk("R5 long re-armed after supply", rst_o, 1'b0);

        supply(1'b1);
        osc_sel = 1'b1;
        supply(1'b0);
        ticks(2 * S, 0); chk("R10 internal tick ignored", rst_o, 1'b1);
        ticks(S - 1, 1); chk("R10 external before end", rst_o, 1'b1);
        ticks(1, 1);     chk("R10 external stretch end", rst_o, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule